// File: doc/BRIEF.md
# Block Lock Protection Controller

This block decides whether modifying operations on a flash array may go ahead, based on per-block protection state. It keeps one lock bit for each 64-Kbyte block and one master lock bit. Each cycle it can take one already-decoded request: an erase, a program, a set of one block's lock, a set of the master lock, or a clear of all block locks. One cycle later it returns either a grant or a deny with a cause code. The array and the command decoder are outside this block.

Protection works at two levels. A block lock bit stops erase and program of that block. The master lock bit stops any change to the block lock bits. Raising the reset pin to its high-voltage level (`hv_reset_i`) overrides both levels. The master bit can only be set while that override is present. A granted lock change runs as a timed busy operation. The bit changes only when the busy period ends. Lock state can be read back through an identifier address space. That space also returns fixed vendor and device codes.

Lock bits are meant to survive a deep power-down, which `rst_ni` stands for. The reset therefore clears only the sequencing state. It does not clear the lock bits, and only an explicit clear operation does that.

Top module: `lock_guard`

## Requirements
- R1: An erase (op code 1) or program (op code 2) to a block whose lock bit is set is denied with cause 1 when `hv_reset_i` is low. The same request to an unlocked block is granted.
- R2: With `hv_reset_i` high, erase and program are granted whatever the state of the block lock bit.
- R3: Set-master (op code 4) is granted only with `hv_reset_i` high. Otherwise it is denied with cause 2 and the master bit stays clear.
- R4: While the master bit is set, set-block (op code 3) and clear-blocks (op code 5) are denied with cause 2 unless `hv_reset_i` is high.
- R5: A granted clear-blocks clears every block lock bit and leaves the master bit unchanged.
- R6: A lock-configuration request (op codes 3, 4, 5) made with `supply_ok_i` low is denied with cause 3, and no bit changes. This check takes priority over all other causes.
- R7: A granted lock configuration holds `busy_o` high for CFG_CYCLES cycles. The bit changes when `busy_o` falls. Requests made while `busy_o` is high produce neither a grant nor a deny.
- R8: A request accepted at a clock edge produces exactly one of `grant_o` or `deny_o`, high for one cycle and visible right after that edge. `deny_cause_o` is 0 whenever `deny_o` is low. Op codes 0, 6 and 7 produce no decision.
- R9: Identifier reads are combinational. Address 0 returns MFR_CODE. Address 1 returns DEV_CODE. Address 3 returns the master state. For each block, address (block index << 16) + 2 returns that block's lock state. A state reads 01h when set and 00h when clear. All other addresses read 00h. The block index is taken from the top address bits.
- R10: `rst_ni` low clears `busy_o` and the decision outputs and cancels a pending lock change. Lock bits keep their values through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencing state |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 3 | Request type: 1 erase, 2 program, 3 set block, 4 set master, 5 clear blocks |
| req_blk_i | input | 3 | Target block index |
| hv_reset_i | input | 1 | Reset pin at high-voltage level (override) |
| supply_ok_i | input | 1 | Programming supply within range |
| grant_o | output | 1 | Request granted (one-cycle pulse) |
| deny_o | output | 1 | Request denied (one-cycle pulse) |
| deny_cause_o | output | 2 | 1 block locked, 2 master lock or override missing, 3 supply invalid |
| busy_o | output | 1 | Lock configuration in progress |
| id_addr_i | input | 19 | Identifier-space read address |
| id_data_o | output | 8 | Identifier-space read data |

## Verification
A wrong lock bit becomes visible in two places. It shows up on the identifier read of that block at once. It also shows up on the next erase or program decision for that block, one cycle after the request. A bit that changes at the wrong time shows up either as a wrong busy length or as identifier data that flips while `busy_o` is still high. A master bit that is set when it should not be makes the next block-lock change come back with cause 2 instead of a grant. A lost pending operation after reset shows up as a block that remains unlocked once the busy window would have ended.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;
  typedef enum logic [2:0] {
    OP_NONE         = 3'd0,
    OP_ERASE        = 3'd1,
    OP_PROGRAM      = 3'd2,
    OP_SET_BLOCK    = 3'd3,
    OP_SET_MASTER   = 3'd4,
    OP_CLEAR_BLOCKS = 3'd5,
    OP_RSVD6        = 3'd6,
    OP_RSVD7        = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_BLOCK  = 2'd1,
    CAUSE_MASTER = 2'd2,
    CAUSE_SUPPLY = 2'd3
  } cause_e;
endpackage

// File: rtl/lock_guard_policy.sv
module lock_guard_policy
  import lock_guard_pkg::*;
(
  input  op_e    op_i,
  input  logic   blk_locked_i,
  input  logic   master_locked_i,
  input  logic   hv_i,
  input  logic   supply_ok_i,
  output logic   known_o,
  output logic   cfg_op_o,
  output logic   allow_o,
  output cause_e cause_o
);
  always_comb begin
    known_o  = 1'b1;
    cfg_op_o = 1'b0;
    allow_o  = 1'b0;
    cause_o  = CAUSE_NONE;
    unique case (op_i)
      OP_ERASE, OP_PROGRAM: begin
        if (blk_locked_i && !hv_i) cause_o = CAUSE_BLOCK;
        else                       allow_o = 1'b1;
      end
      OP_SET_BLOCK, OP_CLEAR_BLOCKS: begin
        cfg_op_o = 1'b1;
        if (!supply_ok_i)                  cause_o = CAUSE_SUPPLY;
        else if (master_locked_i && !hv_i) cause_o = CAUSE_MASTER;
        else                               allow_o = 1'b1;
      end
      OP_SET_MASTER: begin
        cfg_op_o = 1'b1;
        if (!supply_ok_i) cause_o = CAUSE_SUPPLY;
        else if (!hv_i)   cause_o = CAUSE_MASTER;
        else              allow_o = 1'b1;
      end
      default: known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lock_guard_seq.sv
module lock_guard_seq
  import lock_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int CFG_CYCLES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  op_e                           op_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] blk_i,
  output logic                          busy_o,
  output logic [NUM_BLOCKS-1:0]         blk_lock_o,
  output logic                          master_o
);
  localparam int BIW = $clog2(NUM_BLOCKS);
  localparam int CW  = $clog2(CFG_CYCLES + 1);

  logic [CW-1:0]  cnt_q;
  op_e            pend_op_q;
  logic [BIW-1:0] pend_blk_q;
  logic           finish;

  assign finish = (cnt_q == CW'(1));
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      pend_op_q  <= OP_NONE;
      pend_blk_q <= '0;
    end else if (start_i) begin
      cnt_q      <= CW'(CFG_CYCLES);
      pend_op_q  <= op_i;
      pend_blk_q <= blk_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // Nonvolatile state: deliberately left out of reset.
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk_i) begin
      if (finish) begin
        if (pend_op_q == OP_CLEAR_BLOCKS)
          blk_lock_o[b] <= 1'b0;
        else if (pend_op_q == OP_SET_BLOCK && pend_blk_q == BIW'(b))
          blk_lock_o[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (finish && pend_op_q == OP_SET_MASTER) master_o <= 1'b1;
  end

  assert_bits_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |=> ($stable(blk_lock_o) && $stable(master_o)));
  assert_master_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && pend_op_q == OP_CLEAR_BLOCKS) |=> $stable(master_o));
endmodule

// File: rtl/lock_guard_idmap.sv
module lock_guard_idmap #(
  parameter int         NUM_BLOCKS = 8,
  parameter int         BLK_AW     = 16,
  parameter logic [7:0] MFR_CODE   = 8'hA7,
  parameter logic [7:0] DEV_CODE   = 8'h3C
) (
  input  logic [$clog2(NUM_BLOCKS)+BLK_AW-1:0] addr_i,
  input  logic [NUM_BLOCKS-1:0]                blk_lock_i,
  input  logic                                 master_i,
  output logic [7:0]                           data_o
);
  localparam int BIW = $clog2(NUM_BLOCKS);
  localparam int AW  = BIW + BLK_AW;

  logic [BIW-1:0]    blk;
  logic [BLK_AW-1:0] off;
  assign blk = addr_i[AW-1 -: BIW];
  assign off = addr_i[BLK_AW-1:0];

  always_comb begin
    data_o = 8'h00;
    if (addr_i == AW'(0))                data_o = MFR_CODE;
    else if (addr_i == AW'(1))           data_o = DEV_CODE;
    else if (addr_i == AW'(3))           data_o = {7'b0, master_i};
    else if (off == BLK_AW'(2) && 32'(blk) < NUM_BLOCKS)
      data_o = {7'b0, blk_lock_i[blk]};
  end
endmodule

// File: rtl/lock_guard.sv
module lock_guard
  import lock_guard_pkg::*;
#(
  parameter int         NUM_BLOCKS = 8,
  parameter int         BLK_AW     = 16,
  parameter int         CFG_CYCLES = 4,
  parameter logic [7:0] MFR_CODE   = 8'hA7,
  parameter logic [7:0] DEV_CODE   = 8'h3C,
  localparam int        BIW        = $clog2(NUM_BLOCKS),
  localparam int        AW         = BIW + BLK_AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  input  logic [2:0]     req_op_i,
  input  logic [BIW-1:0] req_blk_i,
  input  logic           hv_reset_i,
  input  logic           supply_ok_i,
  output logic           grant_o,
  output logic           deny_o,
  output logic [1:0]     deny_cause_o,
  output logic           busy_o,
  input  logic [AW-1:0]  id_addr_i,
  output logic [7:0]     id_data_o
);
  op_e                   op;
  logic                  known, cfg_op, allow, accept, start;
  cause_e                cause;
  logic [NUM_BLOCKS-1:0] blk_lock;
  logic                  master;

  assign op = op_e'(req_op_i);

  lock_guard_policy u_policy (
    .op_i           (op),
    .blk_locked_i   (blk_lock[req_blk_i]),
    .master_locked_i(master),
    .hv_i           (hv_reset_i),
    .supply_ok_i    (supply_ok_i),
    .known_o        (known),
    .cfg_op_o       (cfg_op),
    .allow_o        (allow),
    .cause_o        (cause)
  );

  assign accept = req_valid_i && !busy_o && known;
  assign start  = accept && allow && cfg_op;

  lock_guard_seq #(.NUM_BLOCKS(NUM_BLOCKS), .CFG_CYCLES(CFG_CYCLES)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .op_i      (op),
    .blk_i     (req_blk_i),
    .busy_o    (busy_o),
    .blk_lock_o(blk_lock),
    .master_o  (master)
  );

  lock_guard_idmap #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_AW(BLK_AW),
                     .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idmap (
    .addr_i    (id_addr_i),
    .blk_lock_i(blk_lock),
    .master_i  (master),
    .data_o    (id_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o      <= 1'b0;
      deny_o       <= 1'b0;
      deny_cause_o <= 2'd0;
    end else begin
      grant_o      <= accept && allow;
      deny_o       <= accept && !allow;
      deny_cause_o <= (accept && !allow) ? cause : CAUSE_NONE;
    end
  end

  assert_decision_has_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || deny_o) |-> $past(req_valid_i));
  assert_busy_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> !(grant_o || deny_o));
  assert_master_needs_hv_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && $past(req_op_i) == OP_SET_MASTER) |-> $past(hv_reset_i));
  assert_locked_block_deny_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && ($past(req_op_i) == OP_ERASE || $past(req_op_i) == OP_PROGRAM)
     && !$past(hv_reset_i)) |-> !$past(blk_lock[req_blk_i]));
  assert_supply_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deny_o && deny_cause_o == CAUSE_SUPPLY) |-> !$past(supply_ok_i));
endmodule

// File: tb/lock_guard_bench.sv
module lock_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CFG = 4;
  localparam logic [7:0] MFR = 8'hA7, DEV = 8'h3C;
  localparam logic [2:0] ERASE = 3'd1, PROG = 3'd2, SETB = 3'd3, SETM = 3'd4, CLRB = 3'd5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, hv = 0, sup = 1;
  logic [2:0] req_op = 0, req_blk = 0;
  logic grant, deny, busy;
  logic [1:0] cause;
  logic [18:0] id_addr = 0;
  logic [7:0] id_data;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lock_guard u_lock_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_blk_i(req_blk), .hv_reset_i(hv), .supply_ok_i(sup),
    .grant_o(grant), .deny_o(deny), .deny_cause_o(cause), .busy_o(busy),
    .id_addr_i(id_addr), .id_data_o(id_data));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic id_read(int blk, int off, output int d);
    id_addr = 19'((blk << 16) + off);
    #1 d = id_data;
  endtask

  task automatic issue(logic [2:0] op, int blk, logic h, logic s,
                       output int g, output int dn, output int c, output int b);
    @(negedge clk);
    req_op = op; req_blk = 3'(blk); hv = h; sup = s; req_valid = 1;
    @(negedge clk);
    g = grant; dn = deny; c = cause; b = busy;
    req_valid = 0; hv = 0; sup = 1;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  // exp_cause 0 means grant expected
  task automatic req_expect(string tag, logic [2:0] op, int blk, logic h, logic s, int exp_cause);
    int g, dn, c, b, n;
    issue(op, blk, h, s, g, dn, c, b);
    check({tag, " grant R8"}, g, exp_cause == 0);
    check({tag, " deny R8"}, dn, exp_cause != 0);
    check({tag, " cause"}, c, exp_cause);
    if (exp_cause == 0 && op >= SETB) begin
      wait_idle(n);
      check({tag, " busy length R7"}, n, CFG);
    end else check({tag, " no busy R7"}, b, 0);
  endtask

  task automatic t_reset;
    int d;
    check("reset busy R10", busy, 0);
    check("reset grant R10", grant, 0);
    check("reset deny R10", deny, 0);
    id_read(0, 0, d); check("id mfr R9", d, MFR);
    id_read(0, 1, d); check("id dev R9", d, DEV);
  endtask

  task automatic t_clear_all;
    int d;
    req_expect("clear with hv R5", CLRB, 0, 1, 1, 0);
    for (int b = 0; b < 8; b++) begin
      id_read(b, 2, d); check("cleared lock R5", d, 0);
    end
  endtask

  task automatic t_supply;
    int d;
    req_expect("set blk3 no supply R6", SETB, 3, 0, 0, 3);
    id_read(3, 2, d); check("blk3 unchanged R6", d, 0);
  endtask

  task automatic t_set_block;
    int d;
    req_expect("set blk2 R7", SETB, 2, 0, 1, 0);
    id_read(2, 2, d); check("blk2 locked R9", d, 1);
    id_read(1, 2, d); check("blk1 unlocked R9", d, 0);
  endtask

  task automatic t_array_gate;
    req_expect("erase locked R1", ERASE, 2, 0, 1, 1);
    req_expect("program locked R1", PROG, 2, 0, 1, 1);
    req_expect("program unlocked R1", PROG, 3, 0, 1, 0);
    req_expect("erase locked hv R2", ERASE, 2, 1, 1, 0);
    req_expect("program locked hv R2", PROG, 2, 1, 0, 0);
  endtask

  task automatic t_busy_ignore;
    int g, dn, c, b, n, d;
    issue(SETB, 1, 0, 1, g, dn, c, b);
    check("set blk1 grant R7", g, 1);
    // second request lands on the edge where the counter reads 3
    issue(ERASE, 2, 0, 1, g, dn, c, b);
    check("busy req no grant R7", g, 0);
    check("busy req no deny R7", dn, 0);
    wait_idle(n);
    check("busy remaining R7", n, CFG - 2);
    id_read(1, 2, d); check("blk1 locked after busy R7", d, 1);
    issue(3'd6, 0, 0, 1, g, dn, c, b);
    check("reserved op silent R8", g + dn, 0);
  endtask

  task automatic t_abort;
    int g, dn, c, b, d;
    issue(SETB, 5, 0, 1, g, dn, c, b);
    check("set blk5 grant R7", g, 1);
    id_read(5, 2, d); check("blk5 not yet set R7", d, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("abort busy cleared R10", busy, 0);
    repeat (CFG + 2) @(negedge clk);
    id_read(5, 2, d); check("abort no change R10", d, 0);
    id_read(2, 2, d); check("blk2 persists R10", d, 1);
    id_read(1, 2, d); check("blk1 persists R10", d, 1);
  endtask

  task automatic t_master;
    int d;
    req_expect("set master no hv R3", SETM, 0, 0, 1, 2);
    id_read(0, 3, d); check("master clear R3", d, 0);
    req_expect("set master no supply R6", SETM, 0, 1, 0, 3);
    req_expect("set master hv R3", SETM, 0, 1, 1, 0);
    id_read(0, 3, d); check("master set R9", d, 1);
  endtask

  task automatic t_master_gate;
    int d;
    req_expect("set blk4 master R4", SETB, 4, 0, 1, 2);
    req_expect("clear master R4", CLRB, 0, 0, 1, 2);
    id_read(2, 2, d); check("blk2 kept R4", d, 1);
    req_expect("set blk4 hv R4", SETB, 4, 1, 1, 0);
    id_read(4, 2, d); check("blk4 locked R4", d, 1);
    req_expect("supply before master R6", SETB, 6, 0, 0, 3);
    req_expect("clear hv R5", CLRB, 0, 1, 1, 0);
    id_read(2, 2, d); check("blk2 cleared R5", d, 0);
    id_read(4, 2, d); check("blk4 cleared R5", d, 0);
    id_read(0, 3, d); check("master kept R5", d, 1);
  endtask

  task automatic t_idmap;
    int d;
    id_read(6, 5, d); check("plain addr R9", d, 0);
    id_read(1, 3, d); check("master only absolute R9", d, 0);
    id_read(7, 2, d); check("top block R9", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clear_all();
    t_supply();
    t_set_block();
    t_array_gate();
    t_busy_ignore();
    t_abort();
    t_master();
    t_master_gate();
    t_idmap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule